// File: doc/BRIEF.md
# Sixty-Four Source Interrupt Controller with APB Register Port

This block gathers up to 64 interrupt sources into one request line for a processor, and software controls it through an APB slave port. Every source has two inputs. One is a level line that counts as active for as long as it is high. The other is a pulse line: a single high cycle latches a sticky flag bit, and that bit stays set until software clears it. A per-source enable bit decides whether a source reaches the pending view. A global enable bit, at position 31 of the control word, decides whether any pending source raises the request output.

Each source also has a byte-wide routing field. The fields are packed four to a word in a bank of sixteen words. At reset each field holds its own source number, and software may rewrite the fields. The APB port never stalls, so there is no back-pressure at the block edge. PREADY stays high and every access completes in its access phase. Software finds the active sources by reading the two pending words.

Top module: `apb_intc`

## Requirements
- R1: After reset the control, enable and flag words are zero and irq_o is low. Each routing byte holds its own source number.
- R2: The enable word for sources 0..31 is at 0x10 and the one for sources 32..63 is at 0x28. Both are read/write, and bit k of a word enables the source it covers (1 = enabled).
- R3: The pending words are read-only, at 0x14 (sources 0..31) and 0x2C (sources 32..63). Each bit reads (level input OR flag bit) AND enable bit. A write to either word changes nothing and raises no error.
- R4: The flag words are at 0x08 (sources 0..31) and 0x20 (sources 32..63). A high pulse input in a cycle sets its flag bit at that clock edge. On a write, a 0 bit clears the flag and a 1 bit leaves it unchanged, so software cannot set a flag.
- R5: If a pulse and a clearing write reach the same flag bit in the same cycle, the bit stays set.
- R6: The control word is at 0x00. Only bit 31 is stored and all other bits read 0. irq_o = bit 31 AND (any pending bit), with no register between the inputs and irq_o.
- R7: The routing bank covers 0x40..0x7C, 16 words of full-word read/write. The field of source s is in the word at 0x40+4*(s/4), bits [31-8*(s%4) -: 8], so bytes run in descending order within the word.
- R8: PREADY is always 1. PSLVERR is 1 in the access phase only when the offset is not one of the offsets above, including any offset whose low two bits are non-zero. Such reads return 0 and such writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) / read (0) |
| paddr | input | 12 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Error for unmapped offsets |
| src_level_i | input | 64 | Level-sensitive source inputs |
| src_pulse_i | input | 64 | Pulse source inputs, latched into flags |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The bench drives a pulse into the same cycle as a write that clears its flag. A design that lets the write win would silently lose that edge. It writes all-ones to a flag word, which exposes a design that lets software create an interrupt, and it writes to the pending words, which exposes one that treats them as storage. It also checks the request line against a disabled global bit while sources are pending, the descending byte order of the routing reset values, and error responses at holes and misaligned offsets that lie next to valid registers.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned ADDR_W      = 12;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned CH_W        = 8;
  localparam int unsigned CTRL_EN_BIT = 31;

  localparam logic [ADDR_W-1:0] CTRL_OFF    = 12'h000;
  localparam logic [ADDR_W-1:0] EN_BASE     = 12'h010;
  localparam logic [ADDR_W-1:0] HALF_STRIDE = 12'h018;
  localparam logic [ADDR_W-1:0] PEND_DELTA  = 12'h004;
  localparam logic [ADDR_W-1:0] FLAG_DELTA  = 12'h008;
  localparam logic [ADDR_W-1:0] MAP_BASE    = 12'h040;

  function automatic logic [ADDR_W-1:0] en_off(int unsigned h);
    return EN_BASE + ADDR_W'(h) * HALF_STRIDE;
  endfunction

  function automatic logic [ADDR_W-1:0] pend_off(int unsigned h);
    return en_off(h) + PEND_DELTA;
  endfunction

  function automatic logic [ADDR_W-1:0] flag_off(int unsigned h);
    return en_off(h) - FLAG_DELTA;
  endfunction
endpackage

// File: rtl/intc_reg_decode.sv
module intc_reg_decode
  import intc_pkg::*;
#(
  parameter int unsigned HALVES    = 2,
  parameter int unsigned MAP_WORDS = 16
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic                 sel_ctrl,
  output logic [HALVES-1:0]    sel_en,
  output logic [HALVES-1:0]    sel_pend,
  output logic [HALVES-1:0]    sel_flag,
  output logic [MAP_WORDS-1:0] sel_map,
  output logic                 hit
);
  assign sel_ctrl = (addr == CTRL_OFF);

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign sel_en[h]   = (addr == en_off(h));
    assign sel_pend[h] = (addr == pend_off(h));
    assign sel_flag[h] = (addr == flag_off(h));
  end

  for (genvar w = 0; w < MAP_WORDS; w++) begin : g_map
    assign sel_map[w] = (addr == (MAP_BASE + ADDR_W'(4 * w)));
  end

  assign hit = sel_ctrl | (|sel_en) | (|sel_pend) | (|sel_flag) | (|sel_map);
endmodule

// File: rtl/intc_src_half.sv
module intc_src_half
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_flag,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] level,
  input  logic [WORD_W-1:0] pulse,
  output logic [WORD_W-1:0] en_q,
  output logic [WORD_W-1:0] flag_q,
  output logic [WORD_W-1:0] pend
);
  logic [WORD_W-1:0] flag_kept;
  logic [WORD_W-1:0] flag_nxt;

  // software may only clear; a new pulse always wins over a clear
  assign flag_kept = wr_flag ? (flag_q & wdata) : flag_q;
  assign flag_nxt  = flag_kept | pulse;
  assign pend      = (level | flag_q) & en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (wr_en) en_q <= wdata;
      flag_q <= flag_nxt;
    end
  end
endmodule

// File: rtl/intc_chan_map.sv
module intc_chan_map
  import intc_pkg::*;
#(
  parameter int unsigned MAP_WORDS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [MAP_WORDS-1:0]        wr_sel,
  input  logic [WORD_W-1:0]           wdata,
  output logic [MAP_WORDS*WORD_W-1:0] words
);
  localparam int unsigned LANES = WORD_W / CH_W;

  function automatic logic [WORD_W-1:0] home_word(int unsigned w);
    logic [WORD_W-1:0] r;
    r = '0;
    for (int unsigned l = 0; l < LANES; l++)
      r[WORD_W-1-l*CH_W -: CH_W] = CH_W'(w * LANES + l);
    return r;
  endfunction

  for (genvar w = 0; w < MAP_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)         words[w*WORD_W +: WORD_W] <= home_word(w);
      else if (wr_sel[w]) words[w*WORD_W +: WORD_W] <= wdata;
    end
  end
endmodule

// File: rtl/apb_intc.sv
module apb_intc
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC = 64
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [WORD_W-1:0] pwdata,
  output logic [WORD_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [N_SRC-1:0]  src_level_i,
  input  logic [N_SRC-1:0]  src_pulse_i,
  output logic              irq_o
);
  localparam int unsigned HALVES    = N_SRC / WORD_W;
  localparam int unsigned MAP_WORDS = N_SRC / (WORD_W / CH_W);

  logic                        access, wr_stb;
  logic                        sel_ctrl, hit;
  logic [HALVES-1:0]           sel_en, sel_pend, sel_flag;
  logic [MAP_WORDS-1:0]        sel_map;
  logic                        ctrl_en_q;
  logic [N_SRC-1:0]            en_all, flag_all, pend_all;
  logic [MAP_WORDS*WORD_W-1:0] map_words;
  logic [WORD_W-1:0]           rd_mux;

  assign access = psel & penable;
  assign wr_stb = access & pwrite;

  intc_reg_decode #(.HALVES(HALVES), .MAP_WORDS(MAP_WORDS)) u_dec (
    .addr(paddr), .sel_ctrl(sel_ctrl), .sel_en(sel_en), .sel_pend(sel_pend),
    .sel_flag(sel_flag), .sel_map(sel_map), .hit(hit)
  );

  always_ff @(posedge pclk) begin
    if (!presetn)              ctrl_en_q <= 1'b0;
    else if (wr_stb & sel_ctrl) ctrl_en_q <= pwdata[CTRL_EN_BIT];
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    intc_src_half u_half (
      .clk(pclk), .rst_n(presetn),
      .wr_en(wr_stb & sel_en[h]), .wr_flag(wr_stb & sel_flag[h]),
      .wdata(pwdata),
      .level(src_level_i[h*WORD_W +: WORD_W]),
      .pulse(src_pulse_i[h*WORD_W +: WORD_W]),
      .en_q(en_all[h*WORD_W +: WORD_W]),
      .flag_q(flag_all[h*WORD_W +: WORD_W]),
      .pend(pend_all[h*WORD_W +: WORD_W])
    );
  end

  intc_chan_map #(.MAP_WORDS(MAP_WORDS)) u_map (
    .clk(pclk), .rst_n(presetn),
    .wr_sel(sel_map & {MAP_WORDS{wr_stb}}),
    .wdata(pwdata), .words(map_words)
  );

  always_comb begin
    rd_mux = '0;
    if (sel_ctrl) rd_mux[CTRL_EN_BIT] = ctrl_en_q;
    for (int h = 0; h < int'(HALVES); h++) begin
      if (sel_en[h])   rd_mux = rd_mux | en_all[h*WORD_W +: WORD_W];
      if (sel_pend[h]) rd_mux = rd_mux | pend_all[h*WORD_W +: WORD_W];
      if (sel_flag[h]) rd_mux = rd_mux | flag_all[h*WORD_W +: WORD_W];
    end
    for (int w = 0; w < int'(MAP_WORDS); w++)
      if (sel_map[w]) rd_mux = rd_mux | map_words[w*WORD_W +: WORD_W];
  end

  assign prdata  = rd_mux;
  assign pready  = 1'b1;
  assign pslverr = access & ~hit;
  assign irq_o   = ctrl_en_q & (|pend_all);
endmodule

// File: rtl/apb_intc_chk.sv
module apb_intc_chk #(
  parameter int unsigned N_SRC = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             psel,
  input logic             penable,
  input logic             pready,
  input logic             pslverr,
  input logic             irq,
  input logic             ctrl_en,
  input logic [N_SRC-1:0] level,
  input logic [N_SRC-1:0] pulse,
  input logic [N_SRC-1:0] flag
);
  AST_READY_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n) pready); // R8
  AST_ERR_ONLY_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> (psel && penable)); // R8
  AST_IRQ_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl_en); // R6
  AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((level | flag) != '0)); // R3
  AST_PULSE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse != '0) |=> ((flag & $past(pulse)) == $past(pulse))); // R5
  AST_FLAG_NO_SOFT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag & ~$past(flag) & ~$past(pulse)) == '0)); // R4
endmodule

bind apb_intc apb_intc_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable),
  .pready(pready), .pslverr(pslverr), .irq(irq_o), .ctrl_en(ctrl_en_q),
  .level(src_level_i), .pulse(src_pulse_i), .flag(flag_all)
);

// File: tb/apb_intc_tb_top.sv
`timescale 1ns/1ps
module apb_intc_tb_top;
  logic        clk = 1'b0;
  logic        rstn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, irq;
  logic [63:0] lvl = '0, pls = '0;

  int n_tests = 0, n_fail = 0;
  bit started = 0;

  bit          m_ctrl;
  logic [63:0] m_en, m_flag;
  logic [31:0] m_map [16];

  always #2.5 clk = ~clk;

  apb_intc dut_i (
    .pclk(clk), .presetn(rstn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .src_level_i(lvl), .src_pulse_i(pls), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model, updated on each rising edge
  always @(posedge clk) begin
    if (!rstn) begin
      m_ctrl = 0; m_en = '0; m_flag = '0;
      for (int w = 0; w < 16; w++)
        m_map[w] = {8'(4*w), 8'(4*w+1), 8'(4*w+2), 8'(4*w+3)};
    end else begin
      if (psel && penable && pwrite) begin
        case (paddr)
          12'h000: m_ctrl = pwdata[31];
          12'h010: m_en[31:0] = pwdata;
          12'h028: m_en[63:32] = pwdata;
          12'h008: m_flag[31:0] = m_flag[31:0] & pwdata;
          12'h020: m_flag[63:32] = m_flag[63:32] & pwdata;
          default: if (paddr >= 12'h040 && paddr < 12'h080 && paddr[1:0] == 2'b00)
                     m_map[(paddr - 12'h040) >> 2] = pwdata;
        endcase
      end
      m_flag = m_flag | pls;
    end
  end

  function automatic void exp_read(input logic [11:0] a, output logic [31:0] d, output bit err);
    logic [63:0] pend;
    pend = (lvl | m_flag) & m_en;
    err = 0; d = '0;
    case (a)
      12'h000: d = {m_ctrl, 31'b0};
      12'h008: d = m_flag[31:0];
      12'h010: d = m_en[31:0];
      12'h014: d = pend[31:0];
      12'h020: d = m_flag[63:32];
      12'h028: d = m_en[63:32];
      12'h02C: d = pend[63:32];
      default: if (a >= 12'h040 && a < 12'h080 && a[1:0] == 2'b00) d = m_map[(a - 12'h040) >> 2];
               else err = 1;
    endcase
  endfunction

  // irq and pready compared every cycle
  always @(negedge clk) begin
    #2;
    if (started) begin
      chk(irq === (m_ctrl & (|((lvl | m_flag) & m_en))), "R6 irq", {63'b0, irq},
          {63'b0, m_ctrl & (|((lvl | m_flag) & m_en))});
      chk(pready === 1'b1, "R8 pready", {63'b0, pready}, 64'd1);
    end
  end

  task automatic apb(input bit wr, input logic [11:0] a, input logic [31:0] d,
                     input logic [63:0] pulse_in_access, input string req);
    logic [31:0] ed; bit ee;
    @(negedge clk);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1; pls = pulse_in_access;
    #1;
    exp_read(a, ed, ee);
    chk(pslverr === ee, {req, " pslverr"}, {63'b0, pslverr}, {63'b0, ee});
    if (!wr) chk(prdata === ed, {req, " prdata"}, {32'b0, prdata}, {32'b0, ed});
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0; pls = '0;
  endtask

  task automatic rd(input logic [11:0] a, input string req);
    apb(0, a, '0, '0, req);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string req);
    apb(1, a, d, '0, req);
  endtask

  task automatic pulse(input logic [63:0] v);
    @(negedge clk); pls = v;
    @(negedge clk); pls = '0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstn = 1;
    started = 1;
    #1;
    chk(irq === 1'b0, "R1 irq after reset", {63'b0, irq}, 64'd0);
    // R1 reset values, R7 descending byte order
    foreach (m_map[w]) rd(12'h040 + 12'(4*w), "R1 map reset");
    rd(12'h040, "R7 word0");
    chk(m_map[0] == 32'h00010203, "R7 model home word0", {32'b0, m_map[0]}, 64'h00010203);
    rd(12'h000, "R1 ctrl"); rd(12'h010, "R1 en lo"); rd(12'h028, "R1 en hi");
    rd(12'h008, "R1 flag lo"); rd(12'h020, "R1 flag hi");
    // R6 only bit 31 stored
    wr(12'h000, 32'hFFFF_FFFF, "R6 ctrl write"); rd(12'h000, "R6 ctrl readback");
    // R2/R3 level source gated by enable
    lvl[5] = 1; lvl[40] = 1;
    rd(12'h014, "R3 pend masked");
    wr(12'h010, 32'h0000_0020, "R2 en lo"); rd(12'h010, "R2 en lo rb"); rd(12'h014, "R3 pend lo");
    wr(12'h028, 32'h0000_0100, "R2 en hi"); rd(12'h02C, "R3 pend hi");
    // R6 global gate off
    wr(12'h000, 32'h0, "R6 ctrl off"); repeat (2) @(negedge clk);
    wr(12'h000, 32'h8000_0000, "R6 ctrl on");
    lvl = '0; repeat (2) @(negedge clk); rd(12'h014, "R3 pend clear");
    // R3 pending writes ignored
    wr(12'h014, 32'hFFFF_FFFF, "R3 pend write"); rd(12'h014, "R3 pend after write");
    wr(12'h02C, 32'hFFFF_FFFF, "R3 pend hi write"); rd(12'h02C, "R3 pend hi after write");
    // R4 pulse latch, no soft set, clear by 0
    pulse(64'h2 << 32);
    rd(12'h020, "R4 flag hi set"); rd(12'h02C, "R4 pend hi masked bit33");
    wr(12'h028, 32'h0000_0002, "R4 en33"); rd(12'h02C, "R4 pend hi bit33");
    wr(12'h020, 32'hFFFF_FFFF, "R4 write ones"); rd(12'h020, "R4 flag kept");
    wr(12'h008, 32'hFFFF_FFFF, "R4 no soft set"); rd(12'h008, "R4 flag lo still 0");
    wr(12'h020, 32'h0, "R4 clear"); rd(12'h020, "R4 flag cleared");
    // R5 pulse concurrent with clear
    pulse(64'h4); pulse(64'h8);
    wr(12'h010, 32'h0000_000C, "R5 enable");
    apb(1, 12'h008, 32'h0, 64'h4, "R5 clear with pulse");
    rd(12'h008, "R5 flag survives");
    chk(m_flag[2] && !m_flag[3], "R5 model flag", m_flag, 64'h4);
    wr(12'h008, 32'h0, "R5 clear"); rd(12'h008, "R5 flag gone");
    // R7 map write/read
    wr(12'h044, 32'hA1B2_C3D4, "R7 map write"); rd(12'h044, "R7 map rb");
    wr(12'h07C, 32'h1122_3344, "R7 map last"); rd(12'h07C, "R7 map last rb"); rd(12'h040, "R7 neighbour");
    // R8 unmapped and misaligned
    rd(12'h004, "R8 hole read"); wr(12'h030, 32'hDEAD_BEEF, "R8 hole write");
    rd(12'h011, "R8 misaligned"); wr(12'h012, 32'h0, "R8 misaligned write");
    rd(12'h010, "R8 en unchanged"); rd(12'h080, "R8 past map"); rd(12'h03C, "R8 below map");
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule